// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast oscillator clock by a 16-bit programmable ratio N and emits one single-cycle pulse every N input cycles. The pulse is meant for a phase comparator and for monitoring. The division is done in the usual pulse-swallow way. A prescaler counts either 15 or 16 input cycles per step. A 4-bit control counter picks the modulus for each prescaler step, and a 12-bit main counter counts the prescaler steps. The whole design is synchronous logic in the oscillator clock domain.

The ratio is split into two fields. M = N[15:4] sets the number of prescaler steps in a period, which is M+1. A = N[3:0] sets how the steps are split between the two moduli. The first 16−A steps divide by 15 and the remaining M+A−15 steps divide by 16, so a period lasts 16·M + A input cycles. That split needs M ≥ 15, which is why the smallest usable ratio is 240. A smaller ratio raises an error flag and is replaced by 240. The ratio input is taken only on the edge that closes a period, so a change written at any other time waits for the current period to finish.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst` is high at a clock edge, `div_out` and `ratio_err` are low after that edge. On the first edge with `rst` low, a period starts and `div_out` is high after that edge.
- R2: For an unsigned ratio N with 240 ≤ N ≤ 65535 (including 240, 40000 and 65535), consecutive rising pulses on `div_out` are exactly N clock cycles apart.
- R3: `div_out` is high for exactly one clock cycle per period.
- R4: A ratio below 240 (for example 0, 100 or 239) gives a period of exactly 240 cycles.
- R5: `ratio_err` is high in the cycle after an edge at which `ratio_in` was below 240. It is low in the cycle after an edge at which `ratio_in` was 240 or more.
- R6: A change of `ratio_in` in the middle of a period leaves the length of that period unchanged. The new value sets the length of the following period.
- R7: A ratio present at the very edge that ends a period sets the length of the next period, even if it was written in the last cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_in | input | 16 | Division ratio N, unsigned |
| div_out | output | 1 | One-cycle pulse once per N cycles |
| ratio_err | output | 1 | Registered flag: ratio below 240 |

## Verification
The event most likely to go wrong is a ratio change that lands on the same edge as the reload at the end of a period. In that cycle, the edge that closes the old period must also capture the new value. The bench provokes this by writing a new ratio exactly one cycle before the predicted final edge. It then checks two things: the closing period keeps its old length, and the next interval matches the freshly written ratio. The same pass also exercises the error flag, because some of those late writes are out-of-range ratios that must be clamped on that very reload.

// File: rtl/psd_pkg.sv
package psd_pkg;
   // smallest ratio for which the 15/16 split has enough steps
   function automatic int unsigned psd_min_ratio(input int unsigned sw);
      return ((32'd1 << sw) - 32'd1) * (32'd1 << sw);
   endfunction
endpackage

// File: rtl/psd_ratio_guard.sv
module psd_ratio_guard #(
   parameter int unsigned RATIO_W  = 16,
   parameter int unsigned SW       = 4,
   parameter bit          CLAMP_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [RATIO_W-1:0] ratio_in,
   output logic [RATIO_W-1:0] ratio_eff,
   output logic               ratio_err
);
   localparam int unsigned MIN_RATIO = psd_pkg::psd_min_ratio(SW);
   localparam logic [RATIO_W-1:0] MIN_V = RATIO_W'(MIN_RATIO);

   logic below;
   assign below = (ratio_in < MIN_V);

   generate
      if (CLAMP_EN) begin : g_clamp
         assign ratio_eff = below ? MIN_V : ratio_in;
      end else begin : g_pass
         assign ratio_eff = ratio_in;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) ratio_err <= 1'b0;
      else     ratio_err <= below;
   end

   AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
      (ratio_in < MIN_V) |=> ratio_err); // R5
   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (ratio_in >= MIN_V) |=> !ratio_err); // R5
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
   parameter int unsigned SW = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic short_next,
   output logic tc
);
   localparam int unsigned PRE = 1 << SW;
   localparam logic [SW-1:0] RELOAD_SHORT = SW'(PRE - 2);
   localparam logic [SW-1:0] RELOAD_LONG  = SW'(PRE - 1);

   logic [SW-1:0] pc_q, pc_n;

   assign tc = (pc_q == '0);

   always_comb begin
      if (tc) pc_n = short_next ? RELOAD_SHORT : RELOAD_LONG;
      else    pc_n = pc_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_n;
   end

   AST_PRE_RELOAD: assert property (@(posedge clk) disable iff (rst)
      tc |=> (pc_q >= RELOAD_SHORT)); // R2
   AST_PRE_COUNT: assert property (@(posedge clk) disable iff (rst)
      !tc |=> (pc_q == $past(pc_q) - 1'b1)); // R2
endmodule

// File: rtl/psd_ctrl.sv
module psd_ctrl #(
   parameter int unsigned RATIO_W = 16,
   parameter int unsigned SW      = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tc,
   input  logic [RATIO_W-1:0] ratio_eff,
   output logic               short_next,
   output logic               period_end
);
   localparam int unsigned MW = RATIO_W - SW;

   logic [MW-1:0] main_q, main_n;
   logic [SW-1:0] ctl_q, ctl_n;
   logic          fast_q, fast_n;
   logic [MW-1:0] m_ld;
   logic [SW-1:0] a_ld;

   assign m_ld = ratio_eff[RATIO_W-1:SW];
   assign a_ld = ratio_eff[SW-1:0];
   assign period_end = tc && (main_q == '0);

   always_comb begin
      main_n = main_q;
      ctl_n  = ctl_q;
      fast_n = fast_q;
      if (period_end) begin
         main_n = m_ld;
         ctl_n  = {SW{1'b1}} - a_ld;
         fast_n = 1'b1;
      end else if (tc) begin
         main_n = main_q - 1'b1;
         if (fast_q) begin
            if (ctl_q == '0) fast_n = 1'b0;
            else             ctl_n  = ctl_q - 1'b1;
         end
      end
   end

   assign short_next = fast_n;

   always_ff @(posedge clk) begin
      if (rst) begin
         main_q <= '0;
         ctl_q  <= '0;
         fast_q <= 1'b0;
      end else begin
         main_q <= main_n;
         ctl_q  <= ctl_n;
         fast_q <= fast_n;
      end
   end

   AST_FAST_RISE: assert property (@(posedge clk) disable iff (rst)
      !fast_q && !period_end |=> !fast_q); // R2
   AST_MAIN_STEP: assert property (@(posedge clk) disable iff (rst)
      tc && !period_end |=> (main_q == $past(main_q) - 1'b1)); // R6
   AST_MAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
      !tc |=> $stable(main_q)); // R6
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
   parameter int unsigned RATIO_W  = 16,
   parameter int unsigned SW       = 4,
   parameter bit          CLAMP_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [RATIO_W-1:0] ratio_in,
   output logic               div_out,
   output logic               ratio_err
);
   generate
      if (SW < 2) begin : g_bad_sw
         $error("SW must be at least 2");
      end
      if (RATIO_W <= 2 * SW) begin : g_bad_w
         $error("RATIO_W must exceed twice SW");
      end
   endgenerate

   logic [RATIO_W-1:0] ratio_eff;
   logic               tc;
   logic               short_next;
   logic               period_end;

   psd_ratio_guard #(.RATIO_W(RATIO_W), .SW(SW), .CLAMP_EN(CLAMP_EN)) u_guard (
      .clk(clk), .rst(rst), .ratio_in(ratio_in),
      .ratio_eff(ratio_eff), .ratio_err(ratio_err));

   psd_prescaler #(.SW(SW)) u_pre (
      .clk(clk), .rst(rst), .short_next(short_next), .tc(tc));

   psd_ctrl #(.RATIO_W(RATIO_W), .SW(SW)) u_ctrl (
      .clk(clk), .rst(rst), .tc(tc), .ratio_eff(ratio_eff),
      .short_next(short_next), .period_end(period_end));

   always_ff @(posedge clk) begin
      if (rst) div_out <= 1'b0;
      else     div_out <= period_end;
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!div_out && !ratio_err)); // R1
   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
      div_out |=> !div_out); // R3
   AST_FIRST_PULSE: assert property (@(posedge clk)
      rst ##1 !rst |=> div_out); // R1
endmodule

// File: tb/test_pulse_swallow_div.sv
module test_pulse_swallow_div;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] ratio_in = 16'd1000;
   logic        div_out;
   logic        ratio_err;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pulse_swallow_div i_pulse_swallow_div (
      .clk(clk), .rst(rst), .ratio_in(ratio_in),
      .div_out(div_out), .ratio_err(ratio_err));

   function automatic int eff(input logic [15:0] n);
      return (n < 16'd240) ? 240 : int'(n);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Called right after a pulse is seen; measures the period that just began.
   // Optionally writes nr at count chg_at.
   task automatic period(input int chg_at, input logic [15:0] nr, input string req);
      int exp = eff(ratio_in);
      int cnt = 0;
      forever begin
         @(negedge clk);
         cnt++;
         if (cnt == 1) chk(div_out == 1'b0, "R3", int'(div_out), 0);
         if (chg_at > 0 && cnt == chg_at + 1)
            chk(ratio_err == (nr < 16'd240), "R5", int'(ratio_err), int'(nr < 16'd240));
         if (div_out) break;
         if (cnt == chg_at) ratio_in = nr;
         if (cnt > 70000) break;
      end
      chk(cnt == exp, req, cnt, exp);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(div_out == 1'b0, "R1", int'(div_out), 0);
      chk(ratio_err == 1'b0, "R1", int'(ratio_err), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(div_out == 1'b1, "R1", int'(div_out), 1);
      period(0, 16'd0, "R2");
      // switch to 240 mid-period (R6), then measure it (R2)
      period(37, 16'd240, "R6");
      period(0, 16'd0, "R2");
      // late writes on the reload edge (R7), incl. out-of-range ones
      period(239, 16'd100, "R7");
      period(0, 16'd0, "R4");
      period(239, 16'd0, "R7");
      period(0, 16'd0, "R4");
      period(239, 16'd239, "R7");
      period(100, 16'd241, "R4");
      period(0, 16'd0, "R2");
      // random ratios, some changed late, some mid-period
      for (int i = 0; i < 14; i++) begin
         logic [15:0] r;
         int p;
         r = 16'(($urandom % 1800) + 150);
         p = eff(ratio_in);
         if (i % 2 == 0) period(p - 1, r, "R7");
         else            period(p / 2, r, "R6");
         period(0, 16'd0, (r < 16'd240) ? "R4" : "R2");
      end
      // large ratios: 40000 then 65535 then back
      period(10, 16'h9C40, "R6");
      period(500, 16'hFFFF, "R6");
      period(40000, 16'd1000, "R6");
      period(0, 16'd0, "R2");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < 190000; c++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule